// File: doc/BRIEF.md
# Host Register Window Bridge

This block lets an external host processor reach a word-wide internal memory and exchange messages with an internal controller through a window of four registers. The host side is asynchronous: active-low chip select, read and write strobes, a two-bit register select and a 16-bit data bus. The bus is modelled as separate input, output and output-enable signals. Each strobe passes through a synchronizer into the internal clock domain. An access takes effect when its strobe is released.

Through the window the host can load a word pointer, stream words to or from memory, and use a mailbox pair. Streaming uses a pointer that steps by one after every data access. Reads are served from a prefetch buffer, so back-to-back reads need no wait. The outgoing mailbox half raises an interrupt while it holds an unread message. An optional swap exchanges the two bytes of every data and mailbox word that crosses the window. The internal memory side is a one-cycle synchronous request port. The internal controller sees the mailbox through a small word-wide strobe interface.

Top module: `hostRegBridge`

## Requirements
- R1: After reset the interrupt is low, the status register reads 0 and the pointer register reads 0.
- R2: The output enable is high only while chip select and read are both low; otherwise the bus is released.
- R3: Writing register select 2 (pointer) loads the pointer with the low MEM_AW bits of the word; reading select 2 returns the pointer zero-extended. Byte swap never applies to it.
- R4: Writing register select 0 (data) stores the word to memory at the pointer, then the pointer advances by one.
- R5: Reading register select 0 returns the memory word at the pointer, then the pointer advances by one, so consecutive reads return consecutive words.
- R6: The pointer wraps from 2^MEM_AW-1 to 0.
- R7: An internal write to the outgoing mailbox sets status bit 0 and raises the interrupt. A host read of register select 1 returns the message, then clears bit 0 and drops the interrupt.
- R8: A host write to register select 1 stores the word for the internal controller and sets status bit 1 and the incoming-full output. An internal read pulse clears both.
- R9: With byte swap enabled, data and mailbox words have bits [15:8] and [7:0] exchanged in both directions. Pointer and status words pass unchanged.
- R10: No memory write occurs while the write strobe is still held low; it happens only after the strobe is released.
- R11: If an internal mailbox write lands in the same cycle as the host mailbox read that would clear the flag, the new message wins: status bit 0 and the interrupt stay set.
- R12: Read and write strobes with chip select high have no effect on memory, pointer or mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostAddr | input | 2 | Register select: 0 data, 1 mailbox, 2 pointer, 3 status |
| hostDataIn | input | DATA_W | Host write data |
| hostDataOut | output | DATA_W | Host read data |
| hostDataOe | output | 1 | Drive enable for the host bus |
| hostIrq | output | 1 | High while the outgoing mailbox holds an unread message |
| swapEn | input | 1 | Byte-swap enable for data and mailbox words |
| cpuOutWr | input | 1 | Internal write pulse to the outgoing mailbox |
| cpuOutData | input | DATA_W | Outgoing message word |
| cpuInRd | input | 1 | Internal read pulse, clears incoming full |
| cpuInData | output | DATA_W | Incoming message word |
| cpuInFull | output | 1 | Incoming mailbox holds a message |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write enable (0 = read) |
| memAddr | output | MEM_AW | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid the cycle after a read request |

## Verification
Two events can meet in the same cycle: the synchronized release of a host mailbox read, which clears the outgoing flag, and an internal write that refills the mailbox. The bench raises the read strobe on a falling clock edge. It counts the two synchronizer stages plus the edge-detect stage, then pulses the internal write so that it covers exactly the edge where the clear acts. The outcome is judged at the ports. The interrupt and status bit 0 must still be set, and the next mailbox read must return the new word and not the old one.

// File: rtl/hostRegPkg.sv
package hostRegPkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_MBX  = 2'b01,
    SEL_PTR  = 2'b10,
    SEL_STAT = 2'b11
  } regSelT;

  typedef struct packed {
    logic wrData;
    logic rdData;
    logic wrMbx;
    logic rdMbx;
    logic wrPtr;
  } ctrlStrobeT;

endpackage

// File: rtl/hostRegCtrl.sv
module hostRegCtrl
  import hostRegPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output ctrlStrobeT        strb,
  output logic [DATA_W-1:0] capData
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] csSync, rdSync, wrSync;
  logic         rdAct, wrAct, rdActQ, wrActQ;
  logic         rdEdge, wrEdge;
  logic [1:0]   capAddr;
  regSelT       sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1;
      rdSync <= '1;
      wrSync <= '1;
    end else begin
      csSync <= {csSync[TOP-1:0], hostCsN};
      rdSync <= {rdSync[TOP-1:0], hostRdN};
      wrSync <= {wrSync[TOP-1:0], hostWrN};
    end
  end

  assign rdAct = !csSync[TOP] && !rdSync[TOP];
  assign wrAct = !csSync[TOP] && !wrSync[TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActQ  <= 1'b0;
      wrActQ  <= 1'b0;
      capAddr <= '0;
      capData <= '0;
    end else begin
      rdActQ <= rdAct;
      wrActQ <= wrAct;
      if (wrAct) begin
        capAddr <= hostAddr;
        capData <= hostDataIn;
      end else if (rdAct) begin
        capAddr <= hostAddr;
      end
    end
  end

  assign rdEdge = rdActQ && !rdAct;
  assign wrEdge = wrActQ && !wrAct;
  assign sel    = regSelT'(capAddr);

  always_comb begin
    strb        = '0;
    strb.wrData = wrEdge && (sel == SEL_DATA);
    strb.wrMbx  = wrEdge && (sel == SEL_MBX);
    strb.wrPtr  = wrEdge && (sel == SEL_PTR);
    strb.rdData = rdEdge && (sel == SEL_DATA);
    strb.rdMbx  = rdEdge && (sel == SEL_MBX);
  end

endmodule

// File: rtl/hostRegDatapath.sv
module hostRegDatapath
  import hostRegPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  logic [DATA_W-1:0] capData,
  input  logic [1:0]        hostAddr,
  input  logic              swapEn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostIrq,
  input  logic              cpuOutWr,
  input  logic [DATA_W-1:0] cpuOutData,
  input  logic              cpuInRd,
  output logic [DATA_W-1:0] cpuInData,
  output logic              cpuInFull,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] PTR_MASK = DATA_W'((64'd1 << MEM_AW) - 64'd1);

  function automatic logic [DATA_W-1:0] laneSwap(input logic [DATA_W-1:0] w);
    return {w[HALF-1:0], w[DATA_W-1:HALF]};
  endfunction

  logic [DATA_W-1:0] ptr, rdBuf, outMbx, inMbx, wordIn, statusWord;
  logic              fetchPend, fetchQ, outFull, inFull;

  assign wordIn   = swapEn ? laneSwap(capData) : capData;
  assign memReq   = strb.wrData || fetchPend;
  assign memWe    = strb.wrData;
  assign memAddr  = ptr[MEM_AW-1:0];
  assign memWdata = wordIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      fetchPend <= 1'b1;
      fetchQ    <= 1'b0;
      rdBuf     <= '0;
    end else begin
      fetchQ <= memReq && !memWe;
      if (fetchQ) rdBuf <= memRdata;
      if (memReq && !memWe) fetchPend <= 1'b0;
      if (strb.wrPtr) begin
        ptr       <= capData & PTR_MASK;
        fetchPend <= 1'b1;
      end else if (strb.wrData || strb.rdData) begin
        ptr       <= (ptr + 1'b1) & PTR_MASK;
        fetchPend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outMbx  <= '0;
      outFull <= 1'b0;
      inMbx   <= '0;
      inFull  <= 1'b0;
    end else begin
      if (strb.rdMbx) outFull <= 1'b0;
      if (cpuOutWr) begin
        outMbx  <= cpuOutData;
        outFull <= 1'b1;
      end
      if (cpuInRd) inFull <= 1'b0;
      if (strb.wrMbx) begin
        inMbx  <= wordIn;
        inFull <= 1'b1;
      end
    end
  end

  assign statusWord = {{(DATA_W-2){1'b0}}, inFull, outFull};
  assign hostIrq    = outFull;
  assign cpuInData  = inMbx;
  assign cpuInFull  = inFull;

  always_comb begin
    case (regSelT'(hostAddr))
      SEL_DATA: hostDataOut = swapEn ? laneSwap(rdBuf) : rdBuf;
      SEL_MBX:  hostDataOut = swapEn ? laneSwap(outMbx) : outMbx;
      SEL_PTR:  hostDataOut = ptr;
      default:  hostDataOut = statusWord;
    endcase
  end

endmodule

// File: rtl/hostRegBridge.sv
module hostRegBridge
  import hostRegPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  output logic              hostIrq,
  input  logic              swapEn,
  input  logic              cpuOutWr,
  input  logic [DATA_W-1:0] cpuOutData,
  input  logic              cpuInRd,
  output logic [DATA_W-1:0] cpuInData,
  output logic              cpuInFull,
  output logic              memReq,
  output logic              memWe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  ctrlStrobeT        strb;
  logic [DATA_W-1:0] capData;

  assign hostDataOe = !hostCsN && !hostRdN;

  hostRegCtrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .strb(strb), .capData(capData)
  );

  hostRegDatapath #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .capData(capData),
    .hostAddr(hostAddr), .swapEn(swapEn),
    .hostDataOut(hostDataOut), .hostIrq(hostIrq),
    .cpuOutWr(cpuOutWr), .cpuOutData(cpuOutData), .cpuInRd(cpuInRd),
    .cpuInData(cpuInData), .cpuInFull(cpuInFull),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: rtl/hostRegChecker.sv
module hostRegChecker #(
  parameter int MEM_AW = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostCsN,
  input logic              hostRdN,
  input logic              hostWrN,
  input logic              hostDataOe,
  input logic              hostIrq,
  input logic              cpuOutWr,
  input logic              cpuInFull,
  input logic              memReq,
  input logic              memWe,
  input logic [MEM_AW-1:0] memAddr
);
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (hostCsN || hostRdN) |-> !hostDataOe); // R2

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> (memReq && !memWe && memAddr == MEM_AW'($past(memAddr) + 1'b1))); // R4

  AST_IRQ_ON_POST: assert property (@(posedge clk) disable iff (!rstN)
    cpuOutWr |=> hostIrq); // R11

  AST_WRITE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (hostWrN && $past(hostWrN))); // R10

  AST_INBOX_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuInFull) |-> (hostWrN && $past(hostWrN))); // R8
endmodule

bind hostRegBridge hostRegChecker #(.MEM_AW(MEM_AW)) uChk (
  .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
  .hostWrN(hostWrN), .hostDataOe(hostDataOe), .hostIrq(hostIrq),
  .cpuOutWr(cpuOutWr), .cpuInFull(cpuInFull), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr)
);

// File: tb/sim_hostRegBridge.sv
`timescale 1ns/1ps
module sim_hostRegBridge;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [1:0] hostAddr = 2'd0;
  logic [DW-1:0] hostDataIn = '0, hostDataOut;
  logic hostDataOe, hostIrq;
  logic swapEn = 1'b0;
  logic cpuOutWr = 1'b0, cpuInRd = 1'b0;
  logic [DW-1:0] cpuOutData = '0, cpuInData;
  logic cpuInFull;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;
  logic [DW-1:0] mem [0:DEPTH-1];

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  hostRegBridge #(.DATA_W(DW), .MEM_AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe), .hostIrq(hostIrq),
    .swapEn(swapEn), .cpuOutWr(cpuOutWr), .cpuOutData(cpuOutData),
    .cpuInRd(cpuInRd), .cpuInData(cpuInData), .cpuInFull(cpuInFull),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i) ^ 16'hC300;
    memRdata = '0;
  end

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    hostAddr = a; hostDataIn = d; hostCsN = 1'b0; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    hostCsN = 1'b1; hostWrN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    hostAddr = a; hostCsN = 1'b0; hostRdN = 1'b0;
    repeat (4) @(negedge clk);
    d = hostDataOut;
    hostCsN = 1'b1; hostRdN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cpuPost(input logic [DW-1:0] d);
    @(negedge clk); cpuOutWr = 1'b1; cpuOutData = d;
    @(negedge clk); cpuOutWr = 1'b0;
  endtask

  task automatic cpuTake();
    @(negedge clk); cpuInRd = 1'b1;
    @(negedge clk); cpuInRd = 1'b0;
  endtask

  task automatic tReset();
    logic [DW-1:0] v;
    chk("R1 irq", DW'(hostIrq), 16'h0);
    chk("R2 oe idle", DW'(hostDataOe), 16'h0);
    hostRead(2'd3, v); chk("R1 status", v, 16'h0);
    hostRead(2'd2, v); chk("R1 pointer", v, 16'h0);
  endtask

  task automatic tBus();
    @(negedge clk); hostCsN = 1'b1; hostRdN = 1'b0;
    @(negedge clk); chk("R2 oe cs high", DW'(hostDataOe), 16'h0);
    hostCsN = 1'b0;
    @(negedge clk); chk("R2 oe active", DW'(hostDataOe), 16'h1);
    hostCsN = 1'b1; hostRdN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic tPointer();
    logic [DW-1:0] v;
    hostWrite(2'd2, 16'h0010); hostRead(2'd2, v); chk("R3 load", v, 16'h0010);
    hostWrite(2'd2, 16'hFC10); hostRead(2'd2, v); chk("R3 mask", v, 16'h0010);
  endtask

  task automatic tDataWrite();
    logic [DW-1:0] v;
    hostWrite(2'd0, 16'h1111);
    hostWrite(2'd0, 16'h2222);
    chk("R4 word0", mem[16'h10], 16'h1111);
    chk("R4 word1", mem[16'h11], 16'h2222);
    hostRead(2'd2, v); chk("R4 ptr step", v, 16'h0012);
  endtask

  task automatic tDataRead();
    logic [DW-1:0] v;
    hostWrite(2'd2, 16'h0020);
    hostRead(2'd0, v); chk("R5 first", v, 16'hC320);
    hostRead(2'd0, v); chk("R5 second", v, 16'hC321);
    hostRead(2'd2, v); chk("R5 ptr step", v, 16'h0022);
  endtask

  task automatic tWrap();
    logic [DW-1:0] v;
    hostWrite(2'd2, 16'h03FF);
    hostWrite(2'd0, 16'hABCD);
    chk("R6 top word", mem[DEPTH-1], 16'hABCD);
    hostRead(2'd2, v); chk("R6 wrap ptr", v, 16'h0000);
    hostRead(2'd0, v); chk("R6 wrapped read", v, 16'hC300);
  endtask

  task automatic tSwap();
    logic [DW-1:0] v;
    swapEn = 1'b1;
    hostWrite(2'd2, 16'h0030); hostRead(2'd2, v); chk("R9 ptr unswapped", v, 16'h0030);
    hostWrite(2'd0, 16'h1234); chk("R9 write swapped", mem[16'h30], 16'h3412);
    hostWrite(2'd2, 16'h0030); hostRead(2'd0, v); chk("R9 read swapped", v, 16'h1234);
    swapEn = 1'b0;
    hostWrite(2'd2, 16'h0030); hostRead(2'd0, v); chk("R9 read plain", v, 16'h3412);
    swapEn = 1'b1;
    cpuPost(16'hA0B1); hostRead(2'd1, v); chk("R9 outbox swapped", v, 16'hB1A0);
    hostWrite(2'd1, 16'h1122); chk("R9 inbox swapped", cpuInData, 16'h2211);
    hostRead(2'd3, v); chk("R9 status unswapped", v, 16'h0002);
    cpuTake();
    swapEn = 1'b0;
  endtask

  task automatic tOutbox();
    logic [DW-1:0] v;
    cpuPost(16'h5A5A);
    chk("R7 irq set", DW'(hostIrq), 16'h1);
    hostRead(2'd3, v); chk("R7 status set", v, 16'h0001);
    hostRead(2'd1, v); chk("R7 message", v, 16'h5A5A);
    chk("R7 irq cleared", DW'(hostIrq), 16'h0);
    hostRead(2'd3, v); chk("R7 status cleared", v, 16'h0000);
  endtask

  task automatic tInbox();
    logic [DW-1:0] v;
    hostWrite(2'd1, 16'h7777);
    chk("R8 full", DW'(cpuInFull), 16'h1);
    chk("R8 data", cpuInData, 16'h7777);
    hostRead(2'd3, v); chk("R8 status", v, 16'h0002);
    cpuTake();
    chk("R8 cleared", DW'(cpuInFull), 16'h0);
    hostRead(2'd3, v); chk("R8 status cleared", v, 16'h0000);
  endtask

  task automatic tHeldWrite();
    int early = 0;
    hostWrite(2'd2, 16'h0040);
    @(negedge clk);
    hostAddr = 2'd0; hostDataIn = 16'hBEEF; hostCsN = 1'b0; hostWrN = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (memReq && memWe) early++;
    end
    chk("R10 no write while low", DW'(early), 16'h0);
    chk("R10 memory untouched", mem[16'h40], 16'hC340);
    hostCsN = 1'b1; hostWrN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 written after release", mem[16'h40], 16'hBEEF);
  endtask

  task automatic tCsIgnored();
    logic [DW-1:0] v;
    @(negedge clk);
    hostAddr = 2'd0; hostDataIn = 16'hDEAD; hostWrN = 1'b0;
    repeat (4) @(negedge clk); hostWrN = 1'b1;
    repeat (4) @(negedge clk); hostRdN = 1'b0;
    repeat (4) @(negedge clk); hostRdN = 1'b1;
    hostAddr = 2'd1; hostWrN = 1'b0;
    repeat (4) @(negedge clk); hostWrN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 memory", mem[16'h41], 16'hC341);
    chk("R12 inbox", DW'(cpuInFull), 16'h0);
    hostRead(2'd2, v); chk("R12 pointer", v, 16'h0041);
  endtask

  task automatic tCollide();
    logic [DW-1:0] v;
    cpuPost(16'h1111);
    @(negedge clk);
    hostAddr = 2'd1; hostCsN = 1'b0; hostRdN = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 old message", hostDataOut, 16'h1111);
    hostCsN = 1'b1; hostRdN = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    cpuOutWr = 1'b1; cpuOutData = 16'h2222;
    @(negedge clk); cpuOutWr = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 irq kept", DW'(hostIrq), 16'h1);
    hostRead(2'd3, v); chk("R11 status kept", v, 16'h0001);
    hostRead(2'd1, v); chk("R11 new message", v, 16'h2222);
    chk("R11 irq after read", DW'(hostIrq), 16'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tBus();
    tPointer();
    tDataWrite();
    tDataRead();
    tWrap();
    tSwap();
    tOutbox();
    tInbox();
    tHeldWrite();
    tCsIgnored();
    tCollide();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule